// File: doc/BRIEF.md
# DMA Burst Dwell Limiter

This block sits beside a DMA engine and decides when the engine must hand the bus back after it has won mastership. Two limits are programmed through one 16-bit control word. One caps the number of completed transfers in a tenure. The other caps the tenure's length in clocks, in steps of eight clocks. Either limit can be switched off by programming zero.

The block never cuts a transfer short. When a limit is met, the release request waits for the current transfer's done strobe, however many wait states have stretched it. If the clock limit runs out between transfers, the request is raised at once, because the bus is already idle. The request is registered and stays high until mastership is withdrawn.

The control word is staged. A write lands in a pending copy, and that copy is loaded into the active limits only on the first cycle of a new tenure. Limits therefore never change in the middle of a tenure.

Top module: `dma_dwell_limiter`

## Requirements
- R1: After reset, `yield_req` is low and both active limits are zero, which means both are disabled.
- R2: Control bits [15:8] set the transfer limit N as an unsigned number. When N is nonzero, the done strobe that brings the tenure's transfer count to N raises `yield_req` on the next cycle.
- R3: A transfer limit of zero disables transfer limiting. Any number of transfers then leaves `yield_req` low, unless the clock limit acts.
- R4: Control bits [7:0] set the clock limit C, which stands for C*8 clocks. The tenure's first cycle (the acquisition cycle) is cycle 0. A nonzero C is reached from cycle C*8 onward. A value of zero disables clock limiting.
- R5: If the clock limit is reached while a transfer is in flight, including one held by `bus_stall`, `yield_req` stays low until that transfer's done strobe. It rises on the following cycle.
- R6: If the clock limit is reached while no transfer is in flight and none starts in that cycle, `yield_req` rises on the next cycle.
- R7: With both limits zero, `yield_req` never asserts during a tenure.
- R8: Once high, `yield_req` stays high while `bus_owned` is held. It goes low on the cycle after `bus_owned` drops.
- R9: The transfer count and the cycle count restart at each new acquisition. Earlier tenures do not carry over.
- R10: A control write made during a tenure does not change that tenure's limits. It applies from the next acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 16 | Control word: [15:8] transfer limit, [7:0] clock limit in units of 8 clocks |
| bus_owned | input | 1 | High while the DMA engine holds bus mastership |
| xfer_start | input | 1 | One-cycle pulse when a bus transfer begins |
| xfer_done | input | 1 | One-cycle pulse when a bus transfer completes |
| bus_stall | input | 1 | Wait/ready stall; high while the current transfer is held |
| yield_req | output | 1 | Registered request to release the bus, raised only at a transfer boundary |

## Verification
The assertions rely on three properties of the engine's behaviour. No transfer starts or completes in the acquisition cycle. A done strobe never arrives while `bus_stall` is high. Every done strobe closes a transfer that a start strobe opened. The stimulus tasks follow all three: each transfer is a start pulse, then a stall phase of chosen length, then a done pulse in a cycle with no stall, and every tenure opens with idle cycles after the grant. A behavioural model in the bench is compared with `yield_req` on every clock. The runs cover long stalls that straddle the clock limit, idle expiry, writes made during a tenure, and re-acquisition.

// File: rtl/dwell_pkg.sv
package dwell_pkg;
  localparam int XLIM_W    = 8;
  localparam int CLIM_W    = 8;
  localparam int GRAN_LOG2 = 3;
  localparam int CFG_W     = XLIM_W + CLIM_W;
  localparam int CCNT_W    = CLIM_W + GRAN_LOG2;

  typedef struct packed {
    logic [XLIM_W-1:0] xfer_lim;
    logic [CLIM_W-1:0] clk_lim;
  } dwell_cfg_t;
endpackage

// File: rtl/dwell_cfg_reg.sv
module dwell_cfg_reg
  import dwell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             acq,
  input  logic             owned_q,
  input  logic             bus_owned,
  output dwell_cfg_t       act_cfg
);
  dwell_cfg_t pend_q, pend_d;
  dwell_cfg_t act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (wr_en) pend_d = dwell_cfg_t'(wr_data);
    if (acq)   act_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign act_cfg = act_q;

  AST_LIMITS_FROZEN_IN_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
    (owned_q && bus_owned) |=> $stable(act_cfg)); // R10
endmodule

// File: rtl/dwell_counters.sv
module dwell_counters
  import dwell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_owned,
  input  logic              xfer_done,
  output logic              acq,
  output logic              owned_q,
  output logic [XLIM_W-1:0] xfer_cnt,
  output logic [CCNT_W-1:0] clk_cnt
);
  localparam logic [XLIM_W-1:0] XMAX = {XLIM_W{1'b1}};
  localparam logic [CCNT_W-1:0] CMAX = {CCNT_W{1'b1}};

  logic              own_q;
  logic [XLIM_W-1:0] xc_q, xc_d;
  logic [CCNT_W-1:0] cc_q, cc_d;
  logic              cnt_en;

  assign acq    = bus_owned & ~own_q;
  assign cnt_en = bus_owned;

  always_comb begin
    xc_d = xc_q;
    cc_d = cc_q;
    if (acq) begin
      xc_d = '0;
      cc_d = CCNT_W'(1);
    end else if (cnt_en) begin
      if (xfer_done && xc_q != XMAX) xc_d = xc_q + 1'b1;
      if (cc_q != CMAX)              cc_d = cc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0;
      xc_q  <= '0;
      cc_q  <= '0;
    end else begin
      own_q <= bus_owned;
      if (acq || cnt_en) begin
        xc_q <= xc_d;
        cc_q <= cc_d;
      end
    end
  end

  assign owned_q  = own_q;
  assign xfer_cnt = xc_q;
  assign clk_cnt  = cc_q;

  AST_COUNTS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    acq |=> (clk_cnt == CCNT_W'(1) && xfer_cnt == '0)); // R9
  AST_CLOCK_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (owned_q && bus_owned) |=> (clk_cnt >= $past(clk_cnt))); // R4
endmodule

// File: rtl/dwell_release.sv
module dwell_release
  import dwell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_owned,
  input  logic              acq,
  input  logic              xfer_start,
  input  logic              xfer_done,
  input  logic              bus_stall,
  input  dwell_cfg_t        act_cfg,
  input  logic [XLIM_W-1:0] xfer_cnt,
  input  logic [CCNT_W-1:0] clk_cnt,
  output logic              yield_req
);
  logic [CCNT_W-1:0] clk_bound;
  logic [XLIM_W:0]   xfer_next;
  logic              clk_over, xfer_over, fire;
  logic              busy_q, busy_d;
  logic              yld_q, yld_d;

  assign clk_bound = {act_cfg.clk_lim, {GRAN_LOG2{1'b0}}};
  assign xfer_next = {1'b0, xfer_cnt} + 1'b1;
  assign clk_over  = (act_cfg.clk_lim != '0) && (clk_cnt >= clk_bound);
  assign xfer_over = (act_cfg.xfer_lim != '0) && (xfer_next >= {1'b0, act_cfg.xfer_lim});

  always_comb begin
    fire = bus_owned && !acq &&
           ((xfer_done && (xfer_over || clk_over)) ||
            (clk_over && !busy_q && !xfer_start));
    if (!bus_owned || acq)  busy_d = 1'b0;
    else if (xfer_start)    busy_d = 1'b1;
    else if (xfer_done)     busy_d = 1'b0;
    else                    busy_d = busy_q;
    yld_d = bus_owned && (yld_q || fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      yld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      yld_q  <= yld_d;
    end
  end

  assign yield_req = yld_q;

  AST_DONE_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !bus_stall); // R5
  AST_QUIET_ACQ_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acq |-> (!xfer_start && !xfer_done)); // R9
  AST_YIELD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(yield_req) |-> $past(xfer_done || !busy_q)); // R5
  AST_YIELD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (yield_req && bus_owned) |=> yield_req); // R8
  AST_YIELD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_owned |=> !yield_req); // R8
  AST_NO_LIMITS_NO_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg == '0 && !yield_req) |=> !yield_req); // R7
  AST_XFER_LIMIT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owned && !acq && xfer_done && act_cfg.xfer_lim != '0 &&
     xfer_next == {1'b0, act_cfg.xfer_lim}) |=> yield_req); // R2
endmodule

// File: rtl/dma_dwell_limiter.sv
module dma_dwell_limiter
  import dwell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  logic             bus_owned,
  input  logic             xfer_start,
  input  logic             xfer_done,
  input  logic             bus_stall,
  output logic             yield_req
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              acq, owned_q;
  logic [XLIM_W-1:0] xfer_cnt;
  logic [CCNT_W-1:0] clk_cnt;
  dwell_cfg_t        act_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dwell_counters u_cnt (
    .clk(clk), .rst_n(rst_int_n), .bus_owned(bus_owned), .xfer_done(xfer_done),
    .acq(acq), .owned_q(owned_q), .xfer_cnt(xfer_cnt), .clk_cnt(clk_cnt)
  );

  dwell_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .acq(acq), .owned_q(owned_q), .bus_owned(bus_owned), .act_cfg(act_cfg)
  );

  dwell_release u_rel (
    .clk(clk), .rst_n(rst_int_n), .bus_owned(bus_owned), .acq(acq),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .bus_stall(bus_stall),
    .act_cfg(act_cfg), .xfer_cnt(xfer_cnt), .clk_cnt(clk_cnt), .yield_req(yield_req)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |=> !yield_req); // R1
endmodule

// File: tb/tb_dma_dwell_limiter.sv
module tb_dma_dwell_limiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [15:0] cfg_wr_data;
  logic        bus_owned, xfer_start, xfer_done, bus_stall;
  logic        yield_req;

  int n_chk  = 0;
  int n_fail = 0;
  string cur_req = "R1";

  int pend, axl, acl, xc, cc;
  bit oq, infl, myld, cov, xov, fire;

  always #4 clk = ~clk;

  dma_dwell_limiter dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .bus_owned(bus_owned), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .bus_stall(bus_stall), .yield_req(yield_req)
  );

  // behavioural reference, written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend = 0; axl = 0; acl = 0; xc = 0; cc = 0;
      oq = 0; infl = 0; myld = 0;
    end else begin
      if (bus_owned && !oq) begin
        axl = pend / 256; acl = pend % 256;
        xc = 0; cc = 1; infl = 0; myld = 0;
      end else if (bus_owned) begin
        cov  = (acl != 0) && (cc >= acl * 8);
        xov  = (axl != 0) && (xc + 1 >= axl);
        fire = (xfer_done && (cov || xov)) || (cov && !infl && !xfer_start);
        if (fire) myld = 1;
        if (cc < 2047) cc++;
        if (xfer_done && xc < 255) xc++;
        if (xfer_start) infl = 1;
        else if (xfer_done) infl = 0;
      end else begin
        myld = 0; infl = 0;
      end
      if (cfg_wr_en) pend = int'(cfg_wr_data);
      oq = bus_owned;
    end
  end

  always @(negedge clk) begin
    n_chk++;
    if (yield_req !== myld) begin
      n_fail++;
      $display("FAIL %s: cycle compare yield_req=%b expected=%b at %0t", cur_req, yield_req, myld, $time);
    end
  end

  task automatic check(input string req, input bit exp);
    n_chk++;
    if (yield_req !== exp) begin
      n_fail++;
      $display("FAIL %s: yield_req=%b expected=%b at %0t", req, yield_req, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic grant();
    bus_owned = 1'b1;
    idle(2);
  endtask

  task automatic drop();
    bus_owned = 1'b0;
    idle(2);
  endtask

  task automatic xfer(input int stall_n);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    bus_stall  = 1'b1;
    idle(stall_n);
    bus_stall  = 1'b0;
    xfer_done  = 1'b1;
    @(negedge clk);
    xfer_done  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    bus_owned = 1'b0; xfer_start = 1'b0; xfer_done = 1'b0; bus_stall = 1'b0;
    idle(3);
    check("R1", 1'b0);
    rst_n = 1'b1;
    idle(5);

    // R1: limits zero after reset, a tenure never yields
    cur_req = "R1";
    grant(); xfer(1); xfer(0); idle(30);
    check("R1", 1'b0);
    drop();

    // R2: transfer limit 3
    cur_req = "R2";
    wr(16'h0300); grant();
    xfer(0); xfer(2); check("R2", 1'b0);
    xfer(0); check("R2", 1'b1);
    // R8: held while owned, cleared after drop
    cur_req = "R8";
    idle(6); check("R8", 1'b1);
    bus_owned = 1'b0; @(negedge clk); check("R8", 1'b0);
    idle(2);

    // R2: transfer limit 1
    cur_req = "R2";
    wr(16'h0100); grant(); xfer(3); check("R2", 1'b1); drop();

    // R5: clock limit 16 passes inside a stalled transfer
    cur_req = "R5";
    wr(16'h0002); grant();
    xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
    bus_stall = 1'b1; idle(25);
    check("R5", 1'b0);
    bus_stall = 1'b0; xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    check("R5", 1'b1);
    drop();

    // R4, R6: clock limit 8 expires while idle
    cur_req = "R6";
    wr(16'h0001); grant();
    idle(5); check("R4", 1'b0);
    idle(4); check("R6", 1'b1);
    drop();

    // R3: transfer limit zero with clock limit 40 cycles
    cur_req = "R3";
    wr(16'h0005); grant();
    for (int k = 0; k < 8; k++) xfer(1);
    check("R3", 1'b0);
    idle(30); check("R4", 1'b1);
    drop();

    // R7: both zero, long tenure
    cur_req = "R7";
    wr(16'h0000); grant();
    for (int k = 0; k < 12; k++) xfer(5);
    idle(300);
    check("R7", 1'b0);
    drop();

    // R10: write during tenure applies next time
    cur_req = "R10";
    wr(16'h0500); grant();
    wr(16'h0100);
    xfer(0); xfer(0); check("R10", 1'b0);
    drop(); grant(); xfer(0); check("R10", 1'b1);
    drop();

    // R9: counts restart on each acquisition
    cur_req = "R9";
    wr(16'h0200); grant(); xfer(0); check("R9", 1'b0);
    drop(); grant(); xfer(0); check("R9", 1'b0);
    xfer(0); check("R9", 1'b1);
    drop();

    // R5: back-to-back transfers across a clock limit of 8
    cur_req = "R5";
    wr(16'h0001); grant();
    xfer(2); xfer(4); xfer(2);
    idle(2);
    drop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule